// File: doc/BRIEF.md
# Page-Mode EEPROM Emulator

This block is a clocked, synthesizable model of a byte-wide parallel EEPROM with a page write. The host side has three active-low strobes: chip select, output enable and write enable. It also has a byte address and a data bus that is split into separate input, output and output-enable signals. A read is presented with chip select and output enable low and write enable high. The byte comes back registered, and the output-enable flag asks the pad ring to drive the bus.

A write byte is taken when the write strobe ends. The write strobe is chip select and write enable both low, with output enable held high. The first byte taken fixes the page, which is the address bits above the six in-page offset bits. Later bytes of that page are collected in a 64-entry page buffer, as long as they keep a minimum spacing. When a load window passes with no further accepted byte, the block starts a self-timed programming cycle. That cycle copies only the loaded buffer positions into the array. From the first accepted byte until the cycle ends, reads return a polling word instead of array data.

All times (load window, minimum byte spacing and programming time) are parameters counted in clock cycles. The array depth follows the address width parameter. The default is 11 bits so that elaboration stays small, and setting it to 15 gives the full 32K x 8 organisation.

Top module: `ee_page_eeprom`

## Requirements
- R1: After reset `data_oe_o` is low and the block is idle, so the first write byte is accepted.
- R2: `data_oe_o` is high in the cycle after an edge at which `ce_ni` and `oe_ni` are low and `we_ni` is high, and it is low after any other edge. A read's data appears on `data_o` on the same edge.
- R3: A byte is loaded on the first edge at which the write strobe (`ce_ni` low, `we_ni` low, `oe_ni` high) is no longer present. It uses the address and data seen at the last edge of the strobe. Bits [5:0] of the address select the buffer slot, and the bits above them name the page.
- R4: While a page is being loaded, a byte whose page bits differ from those of the first byte is ignored. It does not restart the load window.
- R5: A same-page byte that arrives fewer than `MIN_GAP` cycles after the previously accepted byte is ignored.
- R6: Programming starts once `LOAD_WIN` cycles have passed since the last accepted byte. A byte that arrives exactly `LOAD_WIN` cycles later is still accepted, and one that arrives a cycle later is not.
- R7: During loading and programming, a read returns the inverted bit 7 of the last accepted byte in bit 7, with bits 6:0 zero.
- R8: Programming lasts `WRITE_CYC` cycles. A read whose sampling edge lies `LOAD_WIN+WRITE_CYC` cycles after the last accepted load still polls, and the next one returns array data. Buffer slots that were never loaded leave their array bytes unchanged.
- R9: Write strobes during programming change neither the array nor the page buffer.
- R10: A page write takes all 64 offsets. If the same offset is loaded twice, the later byte is the one stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ce_ni | input | 1 | Chip select, active low |
| oe_ni | input | 1 | Output enable, active low |
| we_ni | input | 1 | Write enable, active low |
| addr_i | input | ADDR_W | Byte address; bits [5:0] are the in-page offset |
| data_i | input | DATA_W | Write data from the bus |
| data_o | output | DATA_W | Read data or polling word |
| data_oe_o | output | 1 | Bus drive request |

## Verification
Read data and the drive flag are both due one edge after the read is presented. The bench therefore sets inputs on a falling edge and compares on the next falling edge. A byte load takes effect on the edge after the strobe is released. Each spacing and window case counts edges from that load edge, so a pad of `MIN_GAP-1` idle cycles is the tightest spacing that is accepted, and a pad of `LOAD_WIN-1` is the last one. The end of busy is probed on the two exact sampling edges `LOAD_WIN+WRITE_CYC` and one later. Array contents are only compared after that point.

// File: rtl/ee_pkg.sv
package ee_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_LOAD = 2'd1,
    ST_PROG = 2'd2
  } ee_state_e;
endpackage

// File: rtl/ee_wr_capture.sv
module ee_wr_capture #(
  parameter int ADDR_W = 11,
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ce_ni,
  input  logic              we_ni,
  input  logic              oe_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] data_i,
  output logic              load_o,
  output logic [ADDR_W-1:0] load_addr_o,
  output logic [DATA_W-1:0] load_data_o
);
  logic wr_now, wr_q;

  assign wr_now = !ce_ni && !we_ni && oe_ni;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_q        <= 1'b0;
      load_addr_o <= '0;
      load_data_o <= '0;
    end else begin
      wr_q <= wr_now;
      if (wr_now) begin
        load_addr_o <= addr_i;
        load_data_o <= data_i;
      end
    end
  end

  // trailing edge of the strobe commits the held byte
  assign load_o = wr_q && !wr_now;
endmodule

// File: rtl/ee_page_ctrl.sv
module ee_page_ctrl
  import ee_pkg::*;
#(
  parameter int ADDR_W    = 11,
  parameter int DATA_W    = 8,
  parameter int PAGE_AW   = 6,
  parameter int LOAD_WIN  = 40,
  parameter int MIN_GAP   = 4,
  parameter int WRITE_CYC = 120   // must be >= 2**PAGE_AW
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [ADDR_W-1:0] load_addr_i,
  input  logic [DATA_W-1:0] load_data_i,
  output logic              busy_o,
  output logic              last_msb_o,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_waddr_o,
  output logic [DATA_W-1:0] mem_wdata_o
);
  localparam int PAGE_BYTES = 1 << PAGE_AW;
  localparam int TAG_W      = ADDR_W - PAGE_AW;
  localparam int CW         = $clog2(LOAD_WIN + 1);
  localparam int PW         = $clog2(WRITE_CYC + 1);
  localparam logic [CW-1:0] WIN_LAST = CW'(LOAD_WIN - 1);
  localparam logic [CW-1:0] GAP_MIN  = CW'(MIN_GAP - 1);
  localparam logic [PW-1:0] PROG_LAST = PW'(WRITE_CYC - 1);
  localparam logic [PW-1:0] PAGE_LIM  = PW'(PAGE_BYTES);

  ee_state_e               state_q;
  logic [TAG_W-1:0]        page_q;
  logic [PAGE_BYTES-1:0]   valid_q;
  logic [DATA_W-1:0]       buf_q [PAGE_BYTES];
  logic [CW-1:0]           gap_q;
  logic [PW-1:0]           prog_q;
  logic                    accept;
  logic [TAG_W-1:0]        ld_tag;
  logic [PAGE_AW-1:0]      ld_off;
  logic [PAGE_AW-1:0]      cm_idx;

  assign ld_tag = load_addr_i[ADDR_W-1:PAGE_AW];
  assign ld_off = load_addr_i[PAGE_AW-1:0];

  always_comb begin
    accept = 1'b0;
    if (load_i) begin
      if (state_q == ST_IDLE) accept = 1'b1;
      else if (state_q == ST_LOAD)
        accept = (ld_tag == page_q) && (gap_q >= GAP_MIN);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_IDLE;
      page_q     <= '0;
      valid_q    <= '0;
      gap_q      <= '0;
      prog_q     <= '0;
      last_msb_o <= 1'b0;
    end else begin
      if (accept) last_msb_o <= load_data_i[DATA_W-1];
      unique case (state_q)
        ST_IDLE: if (accept) begin
          state_q <= ST_LOAD;
          page_q  <= ld_tag;
          gap_q   <= '0;
          valid_q <= PAGE_BYTES'(1) << ld_off;
        end
        ST_LOAD: begin
          if (accept) begin
            gap_q           <= '0;
            valid_q[ld_off] <= 1'b1;
          end else if (gap_q == WIN_LAST) begin
            state_q <= ST_PROG;
            prog_q  <= '0;
          end else begin
            gap_q <= gap_q + 1'b1;
          end
        end
        ST_PROG: begin
          if (prog_q == PROG_LAST) begin
            state_q <= ST_IDLE;
            valid_q <= '0;
          end else begin
            prog_q <= prog_q + 1'b1;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk_i) begin
    if (accept) buf_q[ld_off] <= load_data_i;
  end

  // one buffer slot per cycle during the first PAGE_BYTES cycles of programming
  assign cm_idx      = prog_q[PAGE_AW-1:0];
  assign mem_we_o    = (state_q == ST_PROG) && (prog_q < PAGE_LIM) && valid_q[cm_idx];
  assign mem_waddr_o = {page_q, cm_idx};
  assign mem_wdata_o = buf_q[cm_idx];
  assign busy_o      = (state_q != ST_IDLE);

  assert_prog_ignores_load_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_PROG && prog_q != PROG_LAST && load_i) |=> $stable(valid_q));

  assert_window_timeout_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_LOAD && !load_i && gap_q == WIN_LAST) |=> (state_q == ST_PROG));

  assert_page_locked_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_LOAD) |=> (state_q != ST_LOAD || page_q == $past(page_q)));
endmodule

// File: rtl/ee_array.sv
module ee_array #(
  parameter int ADDR_W = 11,
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] waddr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [ADDR_W-1:0] raddr_i,
  output logic [DATA_W-1:0] rdata_o
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[waddr_i] <= wdata_i;
    rdata_o <= mem_q[raddr_i];
  end
endmodule

// File: rtl/ee_page_eeprom.sv
module ee_page_eeprom #(
  parameter int ADDR_W    = 11,
  parameter int DATA_W    = 8,
  parameter int PAGE_AW   = 6,
  parameter int LOAD_WIN  = 40,
  parameter int MIN_GAP   = 4,
  parameter int WRITE_CYC = 120
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ce_ni,
  input  logic              oe_ni,
  input  logic              we_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] data_i,
  output logic [DATA_W-1:0] data_o,
  output logic              data_oe_o
);
  logic              load;
  logic [ADDR_W-1:0] load_addr;
  logic [DATA_W-1:0] load_data;
  logic              busy, last_msb;
  logic              mem_we;
  logic [ADDR_W-1:0] mem_waddr;
  logic [DATA_W-1:0] mem_wdata, arr_rdata;
  logic              poll_sel_q;
  logic [DATA_W-1:0] poll_q;
  logic              rd_cond;

  ee_wr_capture #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_cap (
    .clk_i, .rst_ni, .ce_ni, .we_ni, .oe_ni, .addr_i, .data_i,
    .load_o(load), .load_addr_o(load_addr), .load_data_o(load_data)
  );

  ee_page_ctrl #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .PAGE_AW(PAGE_AW),
    .LOAD_WIN(LOAD_WIN), .MIN_GAP(MIN_GAP), .WRITE_CYC(WRITE_CYC)
  ) u_ctrl (
    .clk_i, .rst_ni,
    .load_i(load), .load_addr_i(load_addr), .load_data_i(load_data),
    .busy_o(busy), .last_msb_o(last_msb),
    .mem_we_o(mem_we), .mem_waddr_o(mem_waddr), .mem_wdata_o(mem_wdata)
  );

  ee_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_arr (
    .clk_i, .we_i(mem_we), .waddr_i(mem_waddr), .wdata_i(mem_wdata),
    .raddr_i(addr_i), .rdata_o(arr_rdata)
  );

  assign rd_cond = !ce_ni && !oe_ni && we_ni;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_oe_o  <= 1'b0;
      poll_sel_q <= 1'b0;
      poll_q     <= '0;
    end else begin
      data_oe_o  <= rd_cond;
      poll_sel_q <= busy;
      poll_q     <= {~last_msb, {(DATA_W-1){1'b0}}};
    end
  end

  assign data_o = poll_sel_q ? poll_q : arr_rdata;

  assert_drive_only_on_read_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    data_oe_o |-> $past(!ce_ni && !oe_ni && we_ni));
endmodule

// File: tb/ee_page_eeprom_tb_top.sv
module ee_page_eeprom_tb_top;
  localparam int AW = 11;
  localparam int LW = 24;
  localparam int MG = 4;
  localparam int WC = 80;

  logic clk = 1'b0;
  logic rst_n;
  logic ce_n, oe_n, we_n;
  logic [AW-1:0] addr;
  logic [7:0] din, dout;
  logic doe;
  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  ee_page_eeprom #(.ADDR_W(AW), .LOAD_WIN(LW), .MIN_GAP(MG), .WRITE_CYC(WC)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .ce_ni(ce_n), .oe_ni(oe_n), .we_ni(we_n),
    .addr_i(addr), .data_i(din), .data_o(dout), .data_oe_o(doe)
  );

  // {accepted, address, data}; page 3 base 192, page 4 base 256
  localparam logic [19:0] VEC [5] = '{
    {1'b1, 11'd194, 8'h15},
    {1'b1, 11'd197, 8'h66},
    {1'b0, 11'd257, 8'hEE},
    {1'b1, 11'd232, 8'h3C},
    {1'b1, 11'd194, 8'h7B}
  };

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act %h exp %h", req, act, exp);
    end
  endtask

  task automatic idle();
    ce_n = 1'b1; oe_n = 1'b1; we_n = 1'b1;
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [7:0] d);
    ce_n = 1'b0; we_n = 1'b0; oe_n = 1'b1; addr = a; din = d;
    @(negedge clk);
    idle();
  endtask

  task automatic rd(input logic [AW-1:0] a, input logic [7:0] exp, input string req);
    ce_n = 1'b0; oe_n = 1'b0; we_n = 1'b1; addr = a;
    @(negedge clk);
    chk(req, {7'd0, doe}, 8'd1);
    chk(req, dout, exp);
  endtask

  task automatic pad(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog act timeout exp finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; idle(); addr = '0; din = '0;
    pad(3);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 oe after reset", {7'd0, doe}, 8'd0);

    // prefill page 3 (R1: first byte accepted from idle, R3)
    for (int i = 0; i < 8; i++) begin
      wr(AW'(192 + i), 8'hA0 + 8'(i));
      pad(MG - 1);
    end
    pad(LW + WC + 4);
    for (int i = 0; i < 8; i++) rd(AW'(192 + i), 8'hA0 + 8'(i), "R3 prefill");
    idle();

    // R2: no drive for write strobe or deselected read
    ce_n = 1'b0; oe_n = 1'b0; we_n = 1'b0;
    @(negedge clk);
    chk("R2 oe during ce oe we low", {7'd0, doe}, 8'd0);
    ce_n = 1'b1; oe_n = 1'b0; we_n = 1'b1;
    @(negedge clk);
    chk("R2 oe while deselected", {7'd0, doe}, 8'd0);
    idle();
    @(negedge clk);

    // prefill page 4, probe busy end exactly (R8)
    for (int i = 0; i < 8; i++) begin
      wr(AW'(256 + i), 8'hB0 + 8'(i));
      if (i != 7) pad(MG - 1);
    end
    pad(LW + WC);
    rd(AW'(263), 8'h00, "R8 still polling at last busy edge");
    rd(AW'(263), 8'hB7, "R8 data after busy");
    idle();
    @(negedge clk);

    // table-driven page write into page 3 (R4, R7, R9, R10)
    for (int v = 0; v < 5; v++) begin
      wr(VEC[v][18:8], VEC[v][7:0]);
      pad(MG - 1);
    end
    rd(AW'(192), 8'h80, "R7 poll during load");
    idle();
    pad(LW + 2);
    rd(AW'(192), 8'h80, "R7 poll during program");
    idle();
    wr(AW'(192), 8'hFF);
    pad(WC + 4);
    rd(AW'(192), 8'hA0, "R9 write during program ignored");
    rd(AW'(193), 8'hA1, "R8 unloaded slot kept");
    rd(AW'(194), 8'h7B, "R10 later byte wins");
    rd(AW'(197), 8'h66, "R3 table byte stored");
    rd(AW'(232), 8'h3C, "R3 table byte stored");
    rd(AW'(257), 8'hB1, "R4 other page ignored");
    idle();
    @(negedge clk);

    // R5: too-close byte dropped
    wr(AW'(256), 8'h11);
    pad(1);
    wr(AW'(257), 8'h22);
    pad(LW + WC + 4);
    rd(AW'(256), 8'h11, "R5 first byte stored");
    rd(AW'(257), 8'hB1, "R5 close byte ignored");
    idle();
    @(negedge clk);

    // R6: byte exactly at window end accepted
    wr(AW'(258), 8'h33);
    pad(LW - 1);
    wr(AW'(259), 8'h44);
    pad(LW + WC + 4);
    rd(AW'(258), 8'h33, "R6 first byte");
    rd(AW'(259), 8'h44, "R6 byte at window edge accepted");
    idle();
    @(negedge clk);

    // R6: one cycle late -> programming already started
    wr(AW'(260), 8'h55);
    pad(LW);
    wr(AW'(261), 8'h66);
    pad(LW + WC + 4);
    rd(AW'(260), 8'h55, "R6 first byte");
    rd(AW'(261), 8'hB5, "R6 late byte ignored");
    idle();
    @(negedge clk);

    // R10: full 64-byte page into page 5
    for (int i = 0; i < 64; i++) begin
      wr(AW'(320 + i), 8'(i * 3 + 1));
      pad(MG - 1);
    end
    pad(LW + WC + 4);
    for (int i = 0; i < 64; i++) rd(AW'(320 + i), 8'(i * 3 + 1), "R10 full page");
    idle();
    @(negedge clk);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule